// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Interface

This block is the bus-facing half of an 8K x 8 serial memory. It watches the clock and data lines of a two-wire bus after they have been oversampled by the system clock. It finds START and STOP conditions and frames bits into bytes. It answers a control byte whose device type code and three strap bits match its own. The SDA line is driven only through an open-drain enable: a high `sda_oe` pulls the line low.

On the memory side the block keeps a word pointer that is 13 bits wide. For each data byte written, it gives a one-cycle write strobe with the pointer and the byte. Read data comes back combinationally through `rd_data` for whatever address `mem_addr` shows. A busy flag from the memory controller stops all acknowledges while a programming cycle runs, so a master can poll until the device answers again. Up to eight devices with different strap settings can share a bus and together cover one contiguous address space.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins reception of a control byte. Bits are sampled on SCL rising edges, most significant bit first.
- R2: A rising SDA while SCL is high (STOP) returns the block to idle. Bytes clocked in after a STOP, without a new START, get no acknowledge and cause no write.
- R3: A control byte is accepted only when bits 7:4 equal 4'b1010 and bits 3:1 equal `dev_sel`. Bit 0 selects read (1) or write (0). On a match the block holds `sda_oe` high across the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next START or STOP.
- R4: If `mem_busy` is high when any received byte completes, no acknowledge is given and the transfer is ignored.
- R5: After a write control byte, two address bytes follow. The first gives address bits 12:8 in its bits 4:0, and its upper three bits are ignored. The second gives bits 7:0. Both are acknowledged.
- R6: Every further written byte is acknowledged and produces a one-cycle `wr_en` with `mem_addr` and `wr_data`. The pointer then increments, wrapping from 8191 to 0.
- R7: After a read control byte, the block sends the byte at `mem_addr` MSB first, with `sda_oe`=1 for a 0 bit. The pointer increments after each byte sent and wraps at 8192.
- R8: A master acknowledge (SDA low in the ninth clock) after a read byte starts the next byte. A missing acknowledge makes the block release SDA and send nothing more until START or STOP.
- R9: A START in the middle of a byte abandons that byte and restarts control-byte reception, so a repeated START can turn a write setup into a read.
- R10: `sda_oe` changes only after a synchronized SCL low has been seen. It never changes while SCL stays high.
- R11: After reset `sda_oe` and `wr_en` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| dev_sel | input | 3 | Strap address of this device |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| mem_busy | input | 1 | Memory controller programming cycle in progress |
| mem_addr | output | 13 | Current word pointer |
| rd_data | input | 8 | Byte stored at `mem_addr` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 8 | Byte to write at `mem_addr` |

## Verification
The hardest situation to reach is a START that lands partway through a byte while the block is in the middle of a write setup. The bench builds this by clocking four bits of an address byte and then issuing a START with SCL high. It then checks that a read control byte is acknowledged and that the byte returned comes from the unchanged pointer. Pointer wrap is reached directly by loading address 0x1FFE or 0x1FFF and then writing or reading across the boundary. A monitor running on every clock watches that the enable never moves during an SCL high phase.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire memory slave.
package twi_pkg;
    // Transfer phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_CTRL,   // receiving control byte
        ST_AHI,    // receiving upper address byte
        ST_ALO,    // receiving lower address byte
        ST_WDAT,   // receiving write data
        ST_RDAT,   // transmitting read data
        ST_SKIP    // not addressed, wait for START or STOP
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Synchronizes SCL and SDA into the clock domain and flags clock edges
// and START/STOP conditions. Assumes the bus idles high; the chains reset high.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_d;
    logic              sda_d;

    // Multi-flop synchronizer chains for both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain[0] <= scl_in;
            sda_chain[0] <= sda_in;
            for (int i = 1; i < STAGES; i++) begin
                scl_chain[i] <= scl_chain[i-1];
                sda_chain[i] <= sda_chain[i-1];
            end
        end
    end

    assign scl_s = scl_chain[STAGES-1];
    assign sda_s = sda_chain[STAGES-1];

    // One-cycle delayed copies used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/twi_shifter.sv
// Shared byte shift register and bit counter. It shifts MSB-first on each
// enabled step, and a load replaces the contents for transmit.
// full is set once W bits have been shifted since the last clear.
module twi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    // Shift register contents
    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (load_en)  data <= load_val;
        else if (shift_en) data <= {data[W-2:0], bit_in};
    end

    // Bit position counter
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (shift_en) cnt <= cnt + 1'b1;
    end

    assign full = (cnt == CW'(W));
endmodule

// File: rtl/twi_addr_ptr.sv
// Word pointer. It holds the upper address part until the lower byte
// arrives, then loads both at once. Increment wraps at 2**AW.
module twi_addr_ptr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_we,
    input  logic [AW-9:0] hi_val,
    input  logic          lo_we,
    input  logic [7:0]    lo_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    logic [AW-9:0] hi_hold;

    // Staging register for the upper address byte
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_hold <= '0;
        else if (hi_we) hi_hold <= hi_val;
    end

    // Pointer load and wrapping increment
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (lo_we) ptr <= {hi_hold, lo_val};
        else if (inc)   ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/twi_mem_slave.sv
// Two-wire memory slave top. It sequences control, address and data bytes,
// makes acknowledges and drives SDA through an open-drain enable.
// All SDA enable changes are taken on a synchronized SCL falling edge.
// rd_data must reflect mem_addr combinationally.
module twi_mem_slave #(
    parameter int         ADDR_W      = 13,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        dev_sel,
    output logic              sda_oe,
    input  logic              mem_busy,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [7:0]        wr_data
);
    import twi_pkg::*;

    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;

    twi_state_e  state;
    logic        ack_phase;
    logic        m_nack;
    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] sr_data;
    logic        sr_full;
    logic        active, ack_ok, byte_end, ack_end;
    logic        sh_clr, sh_en, sh_load;
    logic        st_idle, st_tx;
    logic        ptr_hi_we, ptr_lo_we, ptr_inc;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // Phase decode and acknowledge decision
    always_comb begin
        active   = (state != ST_IDLE) && (state != ST_SKIP);
        byte_end = active && scl_fall && !ack_phase && sr_full;
        ack_end  = active && scl_fall && ack_phase;
        if (mem_busy)              ack_ok = 1'b0;
        else if (state == ST_CTRL) ack_ok = (sr_data[7:4] == DEV_CODE) && (sr_data[3:1] == dev_sel);
        else                       ack_ok = 1'b1;
        st_idle = (state == ST_IDLE);
        st_tx   = (state == ST_RDAT);
    end

    // Shifter control
    always_comb begin
        sh_clr  = start_det | stop_det | ack_end;
        sh_en   = active && scl_rise && !ack_phase && !sr_full;
        sh_load = ack_end && (((state == ST_CTRL) && sr_data[0]) ||
                              ((state == ST_RDAT) && !m_nack));
    end

    twi_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en), .bit_in(sda_s),
        .load_en(sh_load), .load_val(rd_data), .data(sr_data), .full(sr_full)
    );

    // Pointer control
    always_comb begin
        ptr_hi_we = byte_end && (state == ST_AHI) && ack_ok;
        ptr_lo_we = byte_end && (state == ST_ALO) && ack_ok;
        ptr_inc   = (ack_end && (state == ST_WDAT)) ||
                    (byte_end && (state == ST_RDAT));
    end

    twi_addr_ptr #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .hi_we(ptr_hi_we), .hi_val(sr_data[HI_W-1:0]),
        .lo_we(ptr_lo_we), .lo_val(sr_data), .inc(ptr_inc), .ptr(mem_addr)
    );

    // Transfer sequencer, SDA enable and write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ack_phase <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state     <= ST_CTRL;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (byte_end) begin
                if (state == ST_RDAT) begin
                    ack_phase <= 1'b1;
                    sda_oe    <= 1'b0;
                end else if (ack_ok) begin
                    ack_phase <= 1'b1;
                    sda_oe    <= 1'b1;
                    if (state == ST_WDAT) begin
                        wr_en   <= 1'b1;
                        wr_data <= sr_data;
                    end
                end else begin
                    state  <= ST_SKIP;
                    sda_oe <= 1'b0;
                end
            end else if (ack_end) begin
                ack_phase <= 1'b0;
                sda_oe    <= 1'b0;
                case (state)
                    ST_CTRL: begin
                        if (sr_data[0]) begin
                            state  <= ST_RDAT;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state <= ST_AHI;
                        end
                    end
                    ST_AHI:  state <= ST_ALO;
                    ST_ALO:  state <= ST_WDAT;
                    ST_RDAT: begin
                        if (m_nack) state  <= ST_SKIP;
                        else        sda_oe <= ~rd_data[7];
                    end
                    default: state <= state;
                endcase
            end else if (active && scl_fall && (state == ST_RDAT)) begin
                sda_oe <= ~sr_data[7];
            end
        end
    end

    // Capture of the master acknowledge after a transmitted byte
    always_ff @(posedge clk) begin
        if (!rst_n)                                      m_nack <= 1'b1;
        else if (scl_rise && ack_phase && state == ST_RDAT) m_nack <= sda_s;
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
// Property checker for the two-wire memory slave, attached by bind.
// It observes the synchronized clock, the SDA enable, the strobe and the phase.
module twi_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic wr_en,
    input logic mem_busy,
    input logic st_idle,
    input logic st_tx
);
    // R10: enable holds while the synchronized clock stays high
    a_r10_oe_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R6: a write strobe lasts exactly one cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: no acknowledge starts on a received byte while busy
    a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !st_tx) |-> !$past(mem_busy));

    // R2: idle slave never pulls the line
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        st_idle |-> !sda_oe);

    // R6: strobes only follow a received byte, never during transmit
    a_r6_no_strobe_tx: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !st_tx);
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .wr_en(wr_en),
    .mem_busy(mem_busy), .st_idle(st_idle), .st_tx(st_tx)
);

// File: tb/twi_mem_slave_bench.sv
// Bench for the two-wire memory slave. It plays a bus master, models the
// memory contents as a function of address, and compares write strobes
// and the SDA enable behaviour against expectations on every clock.
module twi_mem_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  dev_sel = 3'b101;
    logic        mem_busy = 1'b0;
    logic        sda_oe;
    logic [12:0] mem_addr;
    logic [7:0]  rd_data;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        sda_bus;

    int tests = 0;
    int fails = 0;
    int r10_viol = 0;
    int wr_seen = 0;
    bit done = 0;
    bit prev_oe = 0;
    logic [20:0] exp_wr[$];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'hA5;
    endfunction

    assign rd_data = pat(mem_addr);

    twi_mem_slave u_twi_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .dev_sel(dev_sel), .sda_oe(sda_oe), .mem_busy(mem_busy),
        .mem_addr(mem_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison: write strobes and R10 enable rule
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe != prev_oe && scl_m) r10_viol++;
            if (wr_en) begin
                wr_seen++;
                if (exp_wr.size() == 0) begin
                    chk(0, "R6 unexpected write", {mem_addr, wr_data}, 0);
                end else begin
                    logic [20:0] e;
                    e = exp_wr.pop_front();
                    chk({mem_addr, wr_data} == e, "R6 write addr/data", {mem_addr, wr_data}, e);
                end
            end
        end
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(8);
        sda_m = 1'b0; tick(8);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; tick(4);
        sda_m = 1'b0; tick(4);
        scl_m = 1'b1; tick(8);
        sda_m = 1'b1; tick(8);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        scl_m = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(4);
            scl_m = 1'b1; tick(8);
            scl_m = 1'b0; tick(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(4);
        scl_m = 1'b1; tick(4);
        @(negedge clk) ack = ~sda_bus;
        tick(4);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(4);
            scl_m = 1'b1; tick(4);
            @(negedge clk) b[i] = sda_bus;
            tick(4);
            scl_m = 1'b0; tick(4);
        end
        tick(4);
        sda_m = ~give_ack; tick(4);
        scl_m = 1'b1; tick(8);
        scl_m = 1'b0; tick(4);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        int wr_before;
        tick(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(sda_oe == 0 && wr_en == 0, "R11 outputs after reset", {sda_oe, wr_en}, 0);
        chk(mem_addr == 0, "R11 pointer after reset", mem_addr, 0);

        // R1 R3 R5 R6: write across the top of the array
        bus_start();
        send_byte(8'hAA, ack); chk(ack, "R3 matching write control acked", ack, 1);
        send_byte(8'hFF, ack); chk(ack, "R5 upper address acked", ack, 1);
        send_byte(8'hFE, ack); chk(ack, "R5 lower address acked", ack, 1);
        exp_wr.push_back({13'h1FFE, 8'h11});
        exp_wr.push_back({13'h1FFF, 8'h22});
        exp_wr.push_back({13'h0000, 8'h93});
        send_byte(8'h11, ack); chk(ack, "R6 data acked", ack, 1);
        send_byte(8'h22, ack);
        send_byte(8'h93, ack); chk(ack, "R6 data after wrap acked", ack, 1);
        bus_stop();
        chk(mem_addr == 13'h0001, "R6 pointer wrapped", mem_addr, 1);
        chk(exp_wr.size() == 0, "R6 all writes seen", exp_wr.size(), 0);

        // R7 R8: current address read
        bus_start();
        send_byte(8'hAB, ack); chk(ack, "R3 read control acked", ack, 1);
        read_byte(1, rb); chk(rb == pat(13'h0001), "R7 first read byte", rb, pat(13'h0001));
        read_byte(0, rb); chk(rb == pat(13'h0002), "R8 byte after master ack", rb, pat(13'h0002));
        tick(16);
        chk(sda_oe == 0, "R8 line released after nack", sda_oe, 0);
        bus_stop();

        // R7 R9: random read across the wrap via repeated START
        bus_start();
        send_byte(8'hAA, ack);
        send_byte(8'h1F, ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(8'hAB, ack); chk(ack, "R9 read after repeated START acked", ack, 1);
        read_byte(1, rb); chk(rb == pat(13'h1FFF), "R7 read at top", rb, pat(13'h1FFF));
        read_byte(0, rb); chk(rb == pat(13'h0000), "R7 read wraps to zero", rb, pat(13'h0000));
        bus_stop();

        // R3: wrong type code, then following byte ignored
        bus_start();
        send_byte(8'hBA, ack); chk(!ack, "R3 wrong type code not acked", ack, 0);
        send_byte(8'h00, ack); chk(!ack, "R3 skipped byte not acked", ack, 0);
        bus_stop();

        // R3: wrong strap bits
        bus_start();
        send_byte(8'hA2, ack); chk(!ack, "R3 wrong strap not acked", ack, 0);
        bus_stop();

        // R4: busy suppresses acknowledge
        mem_busy = 1'b1;
        bus_start();
        send_byte(8'hAA, ack); chk(!ack, "R4 busy control not acked", ack, 0);
        bus_stop();
        mem_busy = 1'b0;

        // R2: byte after STOP without START
        wr_before = wr_seen;
        send_byte(8'h55, ack); chk(!ack, "R2 byte after STOP not acked", ack, 0);
        chk(wr_seen == wr_before, "R2 no write after STOP", wr_seen, wr_before);
        bus_stop();

        // R9: START in the middle of an address byte
        bus_start();
        send_byte(8'hAA, ack);
        send_bits(8'h00, 4);
        bus_start();
        send_byte(8'hAB, ack); chk(ack, "R9 control after mid-byte START acked", ack, 1);
        read_byte(0, rb); chk(rb == pat(13'h0001), "R9 pointer unchanged by abandoned byte", rb, pat(13'h0001));
        bus_stop();

        // R10: summary of the per-clock enable monitor
        chk(r10_viol == 0, "R10 enable changed while SCL high", r10_viol, 0);
        chk(exp_wr.size() == 0, "R6 no pending writes", exp_wr.size(), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule